// File: doc/BRIEF.md
# Wait-Mode Power Sequencer

This controller sits next to a CPU core and runs its low-power wait state. A one-cycle wait-for-interrupt strobe from the core moves it from run into wait. In wait, the CPU clock enable is turned off. The oscillator and peripheral clock enables stay on. The two-bit interrupt mask is overridden to 2'b10, the value that enables every interrupt source.

An interrupt request ends the wait with a fixed two-step hand-over:
- a push-status pulse, so the core saves its status register;
- then a service-interrupt pulse;
- then the controller returns to run.

A reset request, taken from any state except the delay itself, starts a fixed stabilisation delay. The CPU clock is held off and a busy flag is raised for the whole delay. A fetch-reset-vector pulse follows, and then run. Reset wins over an interrupt that arrives in the same cycle.

States:
- RUN: normal operation.
- WAIT: CPU clock gated, mask forced.
- PUSH: push-status pulse.
- SERVICE: service-interrupt pulse.
- DELAY: reset stabilisation count.
- FETCH: reset-vector pulse.

Transitions:
- RUN→WAIT on the wait strobe.
- WAIT→PUSH on an interrupt request.
- PUSH→SERVICE and SERVICE→RUN unconditionally.
- Any state except DELAY→DELAY on a reset request.
- DELAY→FETCH when the count reaches 4095.
- FETCH→RUN unconditionally.

Top module: `wfi_power_seq`

## Requirements
- R1: After asynchronous reset the block is in RUN: cpu_clk_en, osc_en and periph_clk_en are 1; mask_force, push_stat, svc_irq, fetch_vec and delay_busy are 0; mask_val is 2'b00.
- R2: A wfi_stb seen in RUN moves the block to WAIT at the next clock edge, where cpu_clk_en is 0 while osc_en and periph_clk_en remain 1.
- R3: In WAIT, mask_force is 1 and mask_val is 2'b10; in every other state, mask_force is 0 and mask_val is 2'b00.
- R4: Without irq_req or rst_req the block stays in WAIT for any number of cycles; further wfi_stb pulses in WAIT change nothing.
- R5: An irq_req seen in WAIT produces push_stat for exactly one cycle, then svc_irq for exactly one cycle, with cpu_clk_en 1 in both, and then RUN. An irq_req outside WAIT has no effect.
- R6: After a reset request, delay_busy is 1 and cpu_clk_en is 0 for exactly DELAY_CYCLES (default 4096) cycles. fetch_vec is then 1 for one cycle with cpu_clk_en 1, followed by RUN.
- R7: When irq_req and rst_req are both seen in the same WAIT cycle, the reset path is taken and push_stat stays 0.
- R8: A rst_req seen in RUN, or in any other state except DELAY, also enters the delay.
- R9: wfi_stb is ignored in every state other than RUN.
- R10: A rst_req seen during the delay neither restarts nor lengthens it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_stb | input | 1 | Wait-for-interrupt strobe from the core |
| irq_req | input | 1 | Interrupt request |
| rst_req | input | 1 | Reset request |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| mask_force | output | 1 | Interrupt mask override active |
| mask_val | output | 2 | Forced interrupt mask value |
| push_stat | output | 1 | Save status register strobe |
| svc_irq | output | 1 | Service interrupt strobe |
| fetch_vec | output | 1 | Fetch reset vector strobe |
| delay_busy | output | 1 | Stabilisation delay in progress |

## Verification
The hardest situation to reach is a disturbance during the long delay. It takes thousands of cycles to get there, and the disturbance is a stray reset or wait strobe that must not change the exact length of the busy window. The bench counts every busy cycle from the ports and injects a reset request and a wait strobe part-way through the count. It also enters the delay through two routes: a simultaneous interrupt and reset in WAIT, and a bare reset in RUN. A sweep over several wait lengths, with stray strobes placed in every short-lived state, covers the remaining transitions.

// File: rtl/wps_pkg.sv
package wps_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_WAIT    = 3'd1,
        ST_PUSH    = 3'd2,
        ST_SERVICE = 3'd3,
        ST_DELAY   = 3'd4,
        ST_FETCH   = 3'd5
    } wps_state_t;

    localparam logic [1:0] MASK_ALL_ON = 2'b10;
endpackage

// File: rtl/wps_delay_ctr.sv
module wps_delay_ctr #(
    parameter int DELAY_CYCLES = 4096,
    localparam int CNT_W = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    // R6: the count advances by one every cycle of the delay
    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    // R6: the count starts from zero on each fresh entry to the delay
    p_cnt_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/wps_fsm.sv
module wps_fsm
    import wps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_stb,
    input  logic       irq_req,
    input  logic       rst_req,
    input  logic       delay_done,
    output wps_state_t state
);
    wps_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:     if (rst_req) nxt = ST_DELAY;
                        else if (wfi_stb) nxt = ST_WAIT;
            ST_WAIT:    if (rst_req) nxt = ST_DELAY;
                        else if (irq_req) nxt = ST_PUSH;
            ST_PUSH:    nxt = rst_req ? ST_DELAY : ST_SERVICE;
            ST_SERVICE: nxt = rst_req ? ST_DELAY : ST_RUN;
            ST_DELAY:   if (delay_done) nxt = ST_FETCH;
            ST_FETCH:   nxt = rst_req ? ST_DELAY : ST_RUN;
            default:    nxt = ST_RUN;
        endcase
    end

    // R2: wait strobe in run enters wait
    p_wfi_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && wfi_stb && !rst_req) |=> (state == ST_WAIT));
    // R7: reset beats interrupt in wait
    p_rst_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && rst_req && irq_req) |=> (state == ST_DELAY));
    // R4: wait held with no wake cause
    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !rst_req && !irq_req) |=> (state == ST_WAIT));
endmodule

// File: rtl/wps_out_dec.sv
module wps_out_dec
    import wps_pkg::*;
(
    input  wps_state_t state,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       periph_clk_en,
    output logic       mask_force,
    output logic [1:0] mask_val,
    output logic       push_stat,
    output logic       svc_irq,
    output logic       fetch_vec,
    output logic       delay_busy
);
    always_comb begin
        cpu_clk_en    = 1'b1;
        osc_en        = 1'b1;
        periph_clk_en = 1'b1;
        mask_force    = 1'b0;
        mask_val      = 2'b00;
        push_stat     = 1'b0;
        svc_irq       = 1'b0;
        fetch_vec     = 1'b0;
        delay_busy    = 1'b0;
        unique case (state)
            ST_RUN:     ;
            ST_WAIT: begin
                cpu_clk_en = 1'b0;
                mask_force = 1'b1;
                mask_val   = MASK_ALL_ON;
            end
            ST_PUSH:    push_stat = 1'b1;
            ST_SERVICE: svc_irq = 1'b1;
            ST_DELAY: begin
                cpu_clk_en = 1'b0;
                delay_busy = 1'b1;
            end
            ST_FETCH:   fetch_vec = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/wfi_power_seq.sv
module wfi_power_seq
    import wps_pkg::*;
#(
    parameter int DELAY_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_stb,
    input  logic       irq_req,
    input  logic       rst_req,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       periph_clk_en,
    output logic       mask_force,
    output logic [1:0] mask_val,
    output logic       push_stat,
    output logic       svc_irq,
    output logic       fetch_vec,
    output logic       delay_busy
);
    wps_state_t state;
    logic       delay_done;
    logic       in_delay;

    assign in_delay = (state == ST_DELAY);

    wps_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_stb    (wfi_stb),
        .irq_req    (irq_req),
        .rst_req    (rst_req),
        .delay_done (delay_done),
        .state      (state)
    );

    wps_delay_ctr #(.DELAY_CYCLES(DELAY_CYCLES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_delay),
        .done  (delay_done)
    );

    wps_out_dec u_dec (
        .state         (state),
        .cpu_clk_en    (cpu_clk_en),
        .osc_en        (osc_en),
        .periph_clk_en (periph_clk_en),
        .mask_force    (mask_force),
        .mask_val      (mask_val),
        .push_stat     (push_stat),
        .svc_irq       (svc_irq),
        .fetch_vec     (fetch_vec),
        .delay_busy    (delay_busy)
    );

    // R5: push is always followed by service
    p_push_then_svc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_stat && !rst_req) |=> svc_irq);
    // R6: end of the busy window is the vector fetch
    p_fetch_after_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(delay_busy) |-> fetch_vec);
    // R8: reset outside the delay starts it
    p_rst_enters_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!delay_busy && rst_req) |=> delay_busy);
    // R5: wake strobes never overlap
    p_strobes_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_stat, svc_irq, fetch_vec, delay_busy}));
    // R3: mask override only with the CPU clock gated
    p_mask_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mask_force |-> (!cpu_clk_en && mask_val == 2'b10));
endmodule

// File: tb/wfi_power_seq_bench.sv
module wfi_power_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi_stb = 1'b0, irq_req = 1'b0, rst_req = 1'b0;
    logic cpu_clk_en, osc_en, periph_clk_en, mask_force;
    logic [1:0] mask_val;
    logic push_stat, svc_irq, fetch_vec, delay_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wfi_power_seq #(.DELAY_CYCLES(DLY)) u_wfi_power_seq (
        .clk(clk), .rst_n(rst_n), .wfi_stb(wfi_stb), .irq_req(irq_req),
        .rst_req(rst_req), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .periph_clk_en(periph_clk_en), .mask_force(mask_force),
        .mask_val(mask_val), .push_stat(push_stat), .svc_irq(svc_irq),
        .fetch_vec(fetch_vec), .delay_busy(delay_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // packed view: {cpu,osc,per,force,mask[1:0],push,svc,fetch,busy}
    function automatic int outs();
        return {cpu_clk_en, osc_en, periph_clk_en, mask_force, mask_val,
                push_stat, svc_irq, fetch_vec, delay_busy};
    endfunction

    localparam int O_RUN   = 10'b1110_00_0000;
    localparam int O_WAIT  = 10'b0111_10_0000;
    localparam int O_PUSH  = 10'b1110_00_1000;
    localparam int O_SVC   = 10'b1110_00_0100;
    localparam int O_DELAY = 10'b0110_00_0001;
    localparam int O_FETCH = 10'b1110_00_0010;

    task automatic go_wait();
        wfi_stb = 1'b1;
        @(negedge clk);
        wfi_stb = 1'b0;
    endtask

    task automatic count_delay(input string req);
        int n = 0;
        while (delay_busy && n < DLY + 10) begin
            n++;
            if (cpu_clk_en) chk({req, " cpu gated in delay"}, 1, 0);
            rst_req = 1'b0;
            if (n == 100) begin
                rst_req = 1'b1;   // R10 stray reset
                wfi_stb = 1'b1;   // R9 stray wait strobe
            end
            @(negedge clk);
            rst_req = 1'b0;
            wfi_stb = 1'b0;
        end
        chk({req, " R6 R10 busy length"}, n, DLY);
        chk({req, " R6 fetch"}, outs(), O_FETCH);
        @(negedge clk);
        chk({req, " R6 back to run"}, outs(), O_RUN);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", outs(), O_RUN);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 run after release", outs(), O_RUN);

        // R5: irq outside wait ignored
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        chk("R5 irq in run ignored", outs(), O_RUN);
        @(negedge clk);
        chk("R5 irq in run ignored later", outs(), O_RUN);

        // Sweep wait lengths, stray wfi placements and wake by interrupt
        for (int d = 1; d <= 6; d++) begin
            go_wait();
            chk("R2 R3 enter wait", outs(), O_WAIT);
            for (int k = 0; k < d * 7; k++) begin
                wfi_stb = (k % 3 == 0);
                @(negedge clk);
                chk("R4 held in wait", outs(), O_WAIT);
            end
            wfi_stb = 1'b0;
            irq_req = 1'b1;
            @(negedge clk);
            irq_req = 1'b0;
            chk("R5 push", outs(), O_PUSH);
            wfi_stb = d[0];               // R9 stray in push
            irq_req = d[1];
            @(negedge clk);
            chk("R5 R9 service", outs(), O_SVC);
            wfi_stb = d[1];               // R9 stray in service
            @(negedge clk);
            wfi_stb = 1'b0;
            irq_req = 1'b0;
            chk("R5 R3 R9 back to run", outs(), O_RUN);
            @(negedge clk);
            chk("R9 still run", outs(), O_RUN);
        end

        // R7: simultaneous wake causes in wait
        go_wait();
        irq_req = 1'b1;
        rst_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        chk("R7 reset wins", outs(), O_DELAY);
        count_delay("R7");

        // R8: reset request from run
        rst_req = 1'b1;
        @(negedge clk);
        chk("R8 delay from run", outs(), O_DELAY);
        count_delay("R8");

        // R8: reset request during push
        go_wait();
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        chk("R5 push before reset", outs(), O_PUSH);
        rst_req = 1'b1;
        @(negedge clk);
        chk("R8 delay from push", outs(), O_DELAY);
        count_delay("R8 push");

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule